// File: doc/BRIEF.md
# Command Processor Immediate ALU

This block is the execute stage for the arithmetic and logic instructions of a small 32-bit command-processor microcontroller. Each cycle it may accept one instruction word with the two source register values already read out. It decodes the opcode and computes the result. One clock later it presents the destination register index, the result and a write enable for the register file. Branches, calls, returns, memory and control-space traffic are handled elsewhere. For those words, and for any word that is not an ALU instruction, the write enable stays low.

Two encodings are accepted: the immediate form, and a register form that takes both source values. The top six bits of the word hold a variable-length opcode. Below 0x30, the upper five bits are the opcode and bit 26 is a repeat flag, which this stage does not act on. A single internal carry/borrow flag is shared by every add and subtract, so a low-word add or subtract followed by its high-word partner operates on a 64-bit register pair.

Top module: `cp_imm_alu`

## Requirements
- R1: The opcode field is instr[31:26]. When it is below 0x30, the opcode is instr[31:27] and instr[26] is a repeat flag with no effect on any output. When it is 0x30 or above, out_wen is 0 the cycle after.
- R2: Outputs are registered with one cycle of latency. In the immediate form, the immediate is instr[15:0] (zero-extended), the source value is src1_val and the destination is instr[20:16]. A cycle without in_valid gives out_wen = 0.
- R3: Add (opcode 0x01) and subtract (0x03) wrap at 32 bits and set the flag to carry-out or borrow. Add-high (0x02) adds the flag in and subtract-high (0x04) subtracts it, and each then updates the flag the same way.
- R4: AND (0x05), OR (0x06) and XOR (0x07) combine the source with the operand. NOT (0x08) returns the inverse of the operand and ignores the source.
- R5: Shift-left (0x09), logical shift-right (0x0A) and arithmetic shift-right (0x0B) use only the low 5 bits of the operand as the amount.
- R6: Rotate-left (0x0C) by the low 5 bits of the operand wraps the bits shifted out back into the low end. An amount of 0 returns the source unchanged.
- R7: The 8-bit multiply (0x0D) returns the zero-extended 16-bit product of source[7:0] and operand[7:0].
- R8: Min (0x0E) and max (0x0F) compare as unsigned. Compare (0x10) returns 0 when equal, 1 when the source is below the operand and 2 when it is above.
- R9: Move-immediate (0x11, immediate form) returns the 16-bit immediate shifted left by instr[25:21], truncated to 32 bits.
- R10: Opcode 0x13 selects the register form: sub-opcode instr[4:0], destination instr[15:11], first source src1_val, second source src2_val. Sub-opcodes 0x01 to 0x10 act as in R3 to R8, with src2_val as the operand. Sub-opcode 0x11 moves src2_val. instr[10:9] has no effect.
- R11: Register-form sub-opcode 0x14 ignores src1_val and returns the index of the highest set bit of src2_val, or 0 when src2_val is 0 or 1.
- R12: Opcodes 0x00, 0x12 and 0x14 to 0x17, and register-form sub-opcodes outside 0x01 to 0x11 and 0x14, give out_wen = 0 and leave the carry flag unchanged.
- R13: Synchronous active-high reset clears out_wen, out_dst, out_result and the carry flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Instruction present this cycle |
| instr | input | 32 | Instruction word |
| src1_val | input | 32 | First source register value |
| src2_val | input | 32 | Second source register value (register form) |
| out_wen | output | 1 | Register-file write enable |
| out_dst | output | 5 | Destination register index |
| out_result | output | 32 | Result value |

## Verification
The assertions check several properties on every cycle: idle cycles and high opcodes never write, NOT ignores its source, the most-significant-bit result stays in range and lands in the register-form destination, min never exceeds either input, and immediate-form writes target instr[20:16]. The bench scenarios are what show that the carry flag is held and chained across 64-bit add and subtract pairs. The same goes for the flag surviving unassigned opcodes and being cleared by reset. The exact values of shifts, rotates, multiply and compare are checked against the bench's reference model over directed corner cases and a long random stream.

// File: rtl/cp_alu_pkg.sv
package cp_alu_pkg;

  localparam int INSTR_W = 32;
  localparam int SEL_W   = 5;
  localparam int REG_W   = 5;
  localparam int IMM_W   = 16;

  typedef enum logic [SEL_W-1:0] {
    OP_NONE  = 5'h00,
    OP_ADD   = 5'h01,
    OP_ADDC  = 5'h02,
    OP_SUB   = 5'h03,
    OP_SUBB  = 5'h04,
    OP_AND   = 5'h05,
    OP_OR    = 5'h06,
    OP_XOR   = 5'h07,
    OP_INV   = 5'h08,
    OP_SLL   = 5'h09,
    OP_SRL   = 5'h0a,
    OP_SRA   = 5'h0b,
    OP_ROL   = 5'h0c,
    OP_MUL8  = 5'h0d,
    OP_MINU  = 5'h0e,
    OP_MAXU  = 5'h0f,
    OP_CMP   = 5'h10,
    OP_MOV   = 5'h11,
    OP_REG2  = 5'h13,
    OP_MSB   = 5'h14
  } alu_op_e;

  localparam logic [5:0] LONG_OPC_BASE = 6'h30;

  localparam logic [1:0] CMP_EQ = 2'd0;
  localparam logic [1:0] CMP_LT = 2'd1;
  localparam logic [1:0] CMP_GT = 2'd2;

endpackage

// File: rtl/cp_alu_decode.sv
module cp_alu_decode
  import cp_alu_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [INSTR_W-1:0] instr,
  input  logic [DATA_W-1:0]  src2_val,
  output alu_op_e            op,
  output logic               writes,
  output logic [REG_W-1:0]   dst,
  output logic [DATA_W-1:0]  opnd_b
);

  localparam int PAD_W = DATA_W - IMM_W;

  logic [5:0]        top6;
  logic [SEL_W-1:0]  opc5;
  logic [SEL_W-1:0]  sub5;
  logic [DATA_W-1:0] imm_ext;
  logic [4:0]        mov_shift;

  assign top6      = instr[31:26];
  assign opc5      = instr[31:27];
  assign sub5      = instr[4:0];
  assign imm_ext   = {{PAD_W{1'b0}}, instr[15:0]};
  assign mov_shift = instr[25:21];

  function automatic logic common_op(input logic [SEL_W-1:0] s);
    return (s >= 5'h01) && (s <= 5'h11);
  endfunction

  always_comb begin
    op     = OP_NONE;
    writes = 1'b0;
    dst    = instr[20:16];
    opnd_b = imm_ext;
    if (top6 < LONG_OPC_BASE) begin
      if (opc5 == OP_REG2) begin
        dst    = instr[15:11];
        opnd_b = src2_val;
        if (common_op(sub5) || (sub5 == OP_MSB)) begin
          op     = alu_op_e'(sub5);
          writes = 1'b1;
        end
      end else if (common_op(opc5)) begin
        op     = alu_op_e'(opc5);
        writes = 1'b1;
        if (opc5 == OP_MOV) begin
          opnd_b = imm_ext << mov_shift;
        end
      end
    end
  end

endmodule

// File: rtl/cp_alu_exec.sv
module cp_alu_exec
  import cp_alu_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int MUL_W  = 8
) (
  input  alu_op_e            op,
  input  logic [DATA_W-1:0]  opnd_a,
  input  logic [DATA_W-1:0]  opnd_b,
  input  logic               flag_in,
  output logic [DATA_W-1:0]  result,
  output logic               flag_out,
  output logic               flag_we
);

  localparam int SH_W   = $clog2(DATA_W);
  localparam int PROD_W = 2 * MUL_W;

  logic [DATA_W:0]       sum_w;
  logic [DATA_W:0]       dif_w;
  logic [DATA_W:0]       cin_w;
  logic [SH_W-1:0]       amt;
  logic [2*DATA_W-1:0]   rot_w;
  logic [PROD_W-1:0]     prod;
  logic [DATA_W-1:0]     msb_idx;
  logic [1:0]            cmp_code;

  assign amt   = opnd_b[SH_W-1:0];
  assign cin_w = {{DATA_W{1'b0}}, flag_in & ((op == OP_ADDC) | (op == OP_SUBB))};
  assign sum_w = {1'b0, opnd_a} + {1'b0, opnd_b} + cin_w;
  assign dif_w = {1'b0, opnd_a} - {1'b0, opnd_b} - cin_w;
  assign rot_w = {opnd_a, opnd_a} << amt;
  assign prod  = opnd_a[MUL_W-1:0] * opnd_b[MUL_W-1:0];

  always_comb begin
    msb_idx = '0;
    for (int i = 0; i < DATA_W; i++) begin
      if (opnd_b[i]) msb_idx = DATA_W'(i);
    end
  end

  always_comb begin
    if (opnd_a == opnd_b)     cmp_code = CMP_EQ;
    else if (opnd_a < opnd_b) cmp_code = CMP_LT;
    else                      cmp_code = CMP_GT;
  end

  always_comb begin
    result   = '0;
    flag_out = flag_in;
    flag_we  = 1'b0;
    unique case (op)
      OP_ADD, OP_ADDC: begin
        result   = sum_w[DATA_W-1:0];
        flag_out = sum_w[DATA_W];
        flag_we  = 1'b1;
      end
      OP_SUB, OP_SUBB: begin
        result   = dif_w[DATA_W-1:0];
        flag_out = dif_w[DATA_W];
        flag_we  = 1'b1;
      end
      OP_AND:  result = opnd_a & opnd_b;
      OP_OR:   result = opnd_a | opnd_b;
      OP_XOR:  result = opnd_a ^ opnd_b;
      OP_INV:  result = ~opnd_b;
      OP_SLL:  result = opnd_a << amt;
      OP_SRL:  result = opnd_a >> amt;
      OP_SRA:  result = DATA_W'($signed(opnd_a) >>> amt);
      OP_ROL:  result = rot_w[2*DATA_W-1:DATA_W];
      OP_MUL8: result = {{(DATA_W-PROD_W){1'b0}}, prod};
      OP_MINU: result = (opnd_a < opnd_b) ? opnd_a : opnd_b;
      OP_MAXU: result = (opnd_a > opnd_b) ? opnd_a : opnd_b;
      OP_CMP:  result = {{(DATA_W-2){1'b0}}, cmp_code};
      OP_MOV:  result = opnd_b;
      OP_MSB:  result = msb_idx;
      default: result = '0;
    endcase
  end

endmodule

// File: rtl/cp_imm_alu.sv
module cp_imm_alu
  import cp_alu_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int MUL_W  = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                in_valid,
  input  logic [INSTR_W-1:0]  instr,
  input  logic [DATA_W-1:0]   src1_val,
  input  logic [DATA_W-1:0]   src2_val,
  output logic                out_wen,
  output logic [REG_W-1:0]    out_dst,
  output logic [DATA_W-1:0]   out_result
);

  alu_op_e            dec_op;
  logic               dec_writes;
  logic [REG_W-1:0]   dec_dst;
  logic [DATA_W-1:0]  dec_b;
  logic [DATA_W-1:0]  ex_result;
  logic               ex_flag;
  logic               ex_flag_we;
  logic               carry_q;

  cp_alu_decode #(.DATA_W(DATA_W)) u_decode (
    .instr    (instr),
    .src2_val (src2_val),
    .op       (dec_op),
    .writes   (dec_writes),
    .dst      (dec_dst),
    .opnd_b   (dec_b)
  );

  cp_alu_exec #(.DATA_W(DATA_W), .MUL_W(MUL_W)) u_exec (
    .op       (dec_op),
    .opnd_a   (src1_val),
    .opnd_b   (dec_b),
    .flag_in  (carry_q),
    .result   (ex_result),
    .flag_out (ex_flag),
    .flag_we  (ex_flag_we)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_wen    <= 1'b0;
      out_dst    <= '0;
      out_result <= '0;
      carry_q    <= 1'b0;
    end else begin
      out_wen <= in_valid & dec_writes;
      if (in_valid && dec_writes) begin
        out_dst    <= dec_dst;
        out_result <= ex_result;
        if (ex_flag_we) carry_q <= ex_flag;
      end
    end
  end

endmodule

// File: rtl/cp_imm_alu_chk.sv
module cp_imm_alu_chk #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic [31:0]       instr,
  input logic [DATA_W-1:0] src1_val,
  input logic [DATA_W-1:0] src2_val,
  input logic              out_wen,
  input logic [4:0]        out_dst,
  input logic [DATA_W-1:0] out_result
);

  p_idle_no_write_r2: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_wen);

  p_long_opc_no_write_r1: assert property (@(posedge clk) disable iff (rst)
    (in_valid && instr[31:30] == 2'b11) |=> !out_wen);

  p_inv_ignores_src_r4: assert property (@(posedge clk) disable iff (rst)
    (in_valid && instr[31:27] == 5'h08) |=>
      (out_wen && out_result == ~{{(DATA_W-16){1'b0}}, $past(instr[15:0])}));

  p_msb_in_range_r11: assert property (@(posedge clk) disable iff (rst)
    (in_valid && instr[31:27] == 5'h13 && instr[4:0] == 5'h14) |=>
      (out_wen && out_result < DATA_W && out_dst == $past(instr[15:11])));

  p_min_bound_r8: assert property (@(posedge clk) disable iff (rst)
    (in_valid && instr[31:27] == 5'h0e) |=>
      (out_result <= $past(src1_val) &&
       out_result <= {{(DATA_W-16){1'b0}}, $past(instr[15:0])}));

  p_imm_dst_r2: assert property (@(posedge clk) disable iff (rst)
    (in_valid && instr[31:27] >= 5'h01 && instr[31:27] <= 5'h11) |=>
      (out_wen && out_dst == $past(instr[20:16])));

  p_reg2_src1_unused_r11: assert property (@(posedge clk) disable iff (rst)
    (in_valid && instr[31:27] == 5'h13 && instr[4:0] == 5'h14 && src2_val <= 1) |=>
      (out_result == '0));

endmodule

bind cp_imm_alu cp_imm_alu_chk #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/test_cp_imm_alu.sv
module test_cp_imm_alu;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [31:0] instr = '0;
  logic [31:0] src1_val = '0;
  logic [31:0] src2_val = '0;
  logic        out_wen;
  logic [4:0]  out_dst;
  logic [31:0] out_result;

  int  n_chk = 0;
  int  n_err = 0;
  bit  m_flag = 1'b0;
  bit  done = 1'b0;

  always #10 clk = ~clk;

  cp_imm_alu i_cp_imm_alu (
    .clk(clk), .rst(rst), .in_valid(in_valid), .instr(instr),
    .src1_val(src1_val), .src2_val(src2_val),
    .out_wen(out_wen), .out_dst(out_dst), .out_result(out_result)
  );

  function automatic logic [31:0] enc_i(input logic [4:0] opc, input bit rep,
      input logic [4:0] s, input logic [4:0] d, input logic [15:0] imm);
    return {opc, rep, s, d, imm};
  endfunction

  function automatic logic [31:0] enc_r(input logic [4:0] sub, input logic [1:0] xm,
      input logic [4:0] d);
    return {5'h13, 1'b0, 5'd1, 5'd2, d, xm, 4'h0, sub};
  endfunction

  // Reference model, written from the requirements
  function automatic void model(input logic [31:0] ins, input logic [31:0] a,
      input logic [31:0] b, inout bit c, output bit w, output logic [4:0] d,
      output logic [31:0] r);
    int top, op, n;
    bit rf;
    logic [31:0] y;
    longint s;
    w = 0; d = 0; r = 0;
    top = int'(ins[31:26]);
    if (top >= 48) return;                       // R1
    op = top >> 1;
    rf = (op == 19);
    if (rf) begin op = int'(ins[4:0]); d = ins[15:11]; y = b; end   // R10
    else    begin d = ins[20:16]; y = {16'h0, ins[15:0]}; end       // R2
    if (rf && op == 20) begin                    // R11
      w = 1;
      for (int i = 0; i < 32; i++) if (b[i]) r = i;
      return;
    end
    if (op < 1 || op > 17) return;               // R12
    w = 1;
    n = int'(y[4:0]);
    case (op)
      1:  begin s = longint'(a) + longint'(y); r = s[31:0]; c = s[32]; end
      2:  begin s = longint'(a) + longint'(y) + c; r = s[31:0]; c = s[32]; end
      3:  begin r = a - y; c = (longint'(a) < longint'(y)); end
      4:  begin r = a - y - c; c = (longint'(a) < longint'(y) + c); end
      5:  r = a & y;
      6:  r = a | y;
      7:  r = a ^ y;
      8:  r = ~y;
      9:  r = a << n;
      10: r = a >> n;
      11: r = $signed(a) >>> n;
      12: r = (n == 0) ? a : ((a << n) | (a >> (32 - n)));
      13: r = a[7:0] * y[7:0];
      14: r = (a < y) ? a : y;
      15: r = (a > y) ? a : y;
      16: r = (a == y) ? 0 : ((a < y) ? 1 : 2);
      default: r = rf ? y : (y << ins[25:21]);
    endcase
  endfunction

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  // Drive at a falling edge, compare at the next falling edge
  task automatic step(input logic [31:0] ins, input logic [31:0] a,
      input logic [31:0] b, input bit v, input string tag);
    bit ew; logic [4:0] ed; logic [31:0] er;
    in_valid = v; instr = ins; src1_val = a; src2_val = b;
    if (v) model(ins, a, b, m_flag, ew, ed, er);
    else begin ew = 0; ed = 0; er = 0; end
    @(negedge clk);
    n_chk++;
    if (out_wen !== ew || (ew && (out_dst !== ed || out_result !== er))) begin
      n_err++;
      $display("FAIL %s: wen/dst/res got %0b/%0d/%h expected %0b/%0d/%h",
               tag, out_wen, out_dst, out_result, ew, ed, er);
    end
  endtask

  task automatic do_reset(input string tag);
    rst = 1'b1; in_valid = 1'b0;
    repeat (2) @(negedge clk);
    n_chk++;
    if (out_wen !== 1'b0 || out_dst !== 5'd0 || out_result !== 32'd0) begin
      n_err++;
      $display("FAIL %s: reset outputs got %0b/%0d/%h expected 0/0/0",
               tag, out_wen, out_dst, out_result);
    end
    m_flag = 1'b0;
    rst = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog: run did not end, got hang expected completion");
      finish_run();
    end
  end

  initial begin
    @(negedge clk);
    do_reset("R13 initial");
    // R1: repeat flag, long opcodes
    step(enc_i(5'h01, 1'b0, 5'd0, 5'd3, 16'h0010), 32'h20, 0, 1, "R1 add rep0");
    step(enc_i(5'h01, 1'b1, 5'd0, 5'd3, 16'h0010), 32'h20, 0, 1, "R1 add rep1");
    for (int t = 48; t < 64; t++)
      step({6'(t), 26'h2a5a5a5}, 32'h1, 32'h2, 1, "R1 long opcode");
    // R2: idle, destination field
    step(enc_i(5'h06, 1'b0, 5'd0, 5'd31, 16'h00ff), 32'h1, 0, 0, "R2 idle");
    step(enc_i(5'h06, 1'b0, 5'd0, 5'd31, 16'h00ff), 32'h100, 0, 1, "R2 dst31");
    // R3: 64-bit add and subtract chains
    step(enc_i(5'h01, 1'b0, 5'd0, 5'd4, 16'h0002), 32'hffff_ffff, 0, 1, "R3 add carry");
    step(enc_i(5'h02, 1'b0, 5'd0, 5'd5, 16'h0000), 32'h0000_0007, 0, 1, "R3 addhi +1");
    step(enc_i(5'h02, 1'b0, 5'd0, 5'd5, 16'h0000), 32'h0000_0007, 0, 1, "R3 addhi +0");
    step(enc_i(5'h03, 1'b0, 5'd0, 5'd4, 16'h0005), 32'h0000_0001, 0, 1, "R3 sub borrow");
    step(enc_i(5'h04, 1'b0, 5'd0, 5'd5, 16'h0000), 32'h0000_0000, 0, 1, "R3 subhi -1");
    step(enc_i(5'h04, 1'b0, 5'd0, 5'd5, 16'h0000), 32'h0000_0009, 0, 1, "R3 subhi chain");
    // R12: flag survives unassigned opcodes
    step(enc_i(5'h01, 1'b0, 5'd0, 5'd4, 16'hffff), 32'hffff_ffff, 0, 1, "R3 set carry");
    step(enc_i(5'h12, 1'b0, 5'd0, 5'd4, 16'h1111), 32'h5, 0, 1, "R12 opc 0x12");
    step(enc_i(5'h00, 1'b0, 5'd0, 5'd4, 16'h1111), 32'h5, 0, 1, "R12 opc 0x00");
    step(enc_i(5'h14, 1'b0, 5'd0, 5'd4, 16'h1111), 32'h5, 0, 1, "R12 imm 0x14");
    step(enc_i(5'h17, 1'b0, 5'd0, 5'd4, 16'h1111), 32'h5, 0, 1, "R12 opc 0x17");
    step(enc_r(5'h12, 2'b00, 5'd6), 32'h5, 32'h6, 1, "R12 sub 0x12");
    step(enc_r(5'h1f, 2'b00, 5'd6), 32'h5, 32'h6, 1, "R12 sub 0x1f");
    step(enc_i(5'h02, 1'b0, 5'd0, 5'd5, 16'h0000), 32'h10, 0, 1, "R12 carry kept");
    // R4
    step(enc_i(5'h05, 1'b0, 5'd0, 5'd1, 16'hf0f0), 32'h1234_5678, 0, 1, "R4 and");
    step(enc_i(5'h06, 1'b0, 5'd0, 5'd1, 16'hf0f0), 32'h1234_5678, 0, 1, "R4 or");
    step(enc_i(5'h07, 1'b0, 5'd0, 5'd1, 16'hf0f0), 32'h1234_5678, 0, 1, "R4 xor");
    step(enc_i(5'h08, 1'b0, 5'd0, 5'd1, 16'h00ff), 32'hdead_beef, 0, 1, "R4 not");
    // R5
    step(enc_i(5'h09, 1'b0, 5'd0, 5'd2, 16'h0025), 32'h0000_0003, 0, 1, "R5 shl low5");
    step(enc_i(5'h0a, 1'b0, 5'd0, 5'd2, 16'h001f), 32'h8000_0000, 0, 1, "R5 ushr");
    step(enc_i(5'h0b, 1'b0, 5'd0, 5'd2, 16'h0004), 32'h8000_0010, 0, 1, "R5 ishr neg");
    // R6
    step(enc_i(5'h0c, 1'b0, 5'd0, 5'd2, 16'h0004), 32'h8000_0001, 0, 1, "R6 rot 4");
    step(enc_i(5'h0c, 1'b0, 5'd0, 5'd2, 16'h0020), 32'h8000_0001, 0, 1, "R6 rot 0");
    // R7
    step(enc_i(5'h0d, 1'b0, 5'd0, 5'd2, 16'h01ff), 32'h0000_01ff, 0, 1, "R7 mul8");
    // R8
    step(enc_i(5'h0e, 1'b0, 5'd0, 5'd2, 16'h8000), 32'hffff_0000, 0, 1, "R8 min");
    step(enc_i(5'h0f, 1'b0, 5'd0, 5'd2, 16'h8000), 32'hffff_0000, 0, 1, "R8 max");
    step(enc_i(5'h10, 1'b0, 5'd0, 5'd2, 16'h0042), 32'h42, 0, 1, "R8 cmp eq");
    step(enc_i(5'h10, 1'b0, 5'd0, 5'd2, 16'h0042), 32'h41, 0, 1, "R8 cmp lt");
    step(enc_i(5'h10, 1'b0, 5'd0, 5'd2, 16'h0042), 32'h8000_0000, 0, 1, "R8 cmp gt");
    // R9
    step(enc_i(5'h11, 1'b0, 5'd16, 5'd7, 16'habcd), 32'h9, 0, 1, "R9 movi 16");
    step(enc_i(5'h11, 1'b0, 5'd20, 5'd7, 16'habcd), 32'h9, 0, 1, "R9 movi trunc");
    // R10
    step(enc_r(5'h01, 2'b00, 5'd9), 32'h7000_0000, 32'h9000_0001, 1, "R10 add xm0");
    step(enc_r(5'h02, 2'b11, 5'd9), 32'h1, 32'h2, 1, "R10 addhi xm3");
    step(enc_r(5'h0c, 2'b10, 5'd9), 32'h1234_5678, 32'h0000_0108, 1, "R10 rot");
    step(enc_r(5'h11, 2'b01, 5'd9), 32'h1, 32'hcafe_f00d, 1, "R10 mov");
    step(enc_r(5'h08, 2'b00, 5'd9), 32'h1, 32'h0f0f_0f0f, 1, "R10 not");
    // R11
    step(enc_r(5'h14, 2'b00, 5'd8), 32'hffff_ffff, 32'h0, 1, "R11 msb 0");
    step(enc_r(5'h14, 2'b00, 5'd8), 32'hffff_ffff, 32'h1, 1, "R11 msb 1");
    step(enc_r(5'h14, 2'b00, 5'd8), 32'h0, 32'h8000_0000, 1, "R11 msb 31");
    step(enc_r(5'h14, 2'b00, 5'd8), 32'h0, 32'h0001_0010, 1, "R11 msb 16");
    // R13: reset clears the flag
    step(enc_i(5'h01, 1'b0, 5'd0, 5'd4, 16'h0001), 32'hffff_ffff, 0, 1, "R13 set carry");
    do_reset("R13 mid-run");
    step(enc_i(5'h02, 1'b0, 5'd0, 5'd5, 16'h0000), 32'h3, 0, 1, "R13 carry cleared");
    // Random stream, every cycle against the model (R3 R10 R12)
    for (int k = 0; k < 600; k++) begin
      logic [31:0] ins;
      logic [31:0] a, b;
      ins = $urandom;
      a = ($urandom_range(0, 3) == 0) ? 32'hffff_ffff : $urandom;
      b = $urandom;
      if ($urandom_range(0, 3) == 0) ins[31:26] = {5'h13, ins[26]};
      else if ($urandom_range(0, 7) != 0) ins[31:27] = 5'($urandom_range(0, 23));
      step(ins, a, b, ($urandom_range(0, 7) != 0), "R12 random");
    end
    step(0, 0, 0, 0, "R2 idle end");
    done = 1'b1;
    finish_run();
  end

endmodule